// File: doc/BRIEF.md
# Boot-time configuration header loader

At power-up this block fetches the first eight bytes of a 256-byte two-wire serial memory through a plain request/response byte-read port. A bus engine outside the block serves that port. The block reads the bytes one at a time in ascending address order. Its first task is to check that the two leading bytes carry the expected signature value. When they do, the block enters the normal bridge mode and keeps the remaining header fields. When the signature is wrong, or the memory refuses or never answers a read, the block drops into board manufacturing test mode. In that mode every configuration output stays at zero.

In normal mode the block also works out the transfer timing modes for the storage port. It takes the enables from the header and the capability masks that the attached drive reports, and picks the highest mode that both sides allow. PIO mode 0 is always available as the floor. The UDMA choice is limited to the legal modes 2 and 4. Which UDMA master enable applies depends on whether the drive reports itself as packet-command (ATAPI) or plain ATA. The block also catches one illegal combination of the reset-method flags, reports it, and falls back to a safe setting.

Top module: `cfg_loader`

## Requirements
- R1: The block reads only header addresses 0 to 7, in ascending order, with the device address output fixed at 0x04. It keeps one read outstanding and holds `rd_req` and `rd_addr` steady until `rd_ack` or `rd_nak` arrives.
- R2: When bytes 0 and 1 both read 0x4D and all eight bytes have been read, `done` pulses high for exactly one cycle and `test_mode` stays 0.
- R3: If byte 0 or byte 1 differs from 0x4D, the block stops reading right after that byte, raises `test_mode` and pulses `done`. In test mode `rd_req` stays low, every configuration output reads 0, `pio_mode` is 0 and `udma_en` is 0, whatever the drive inputs are.
- R4: A `rd_nak`, or no response within `RSP_TIMEOUT` cycles (default 64) of a request, also selects test mode. The timeout never fires before that many cycles have passed.
- R5: In normal mode, `init_tmo` equals byte 3 and `vcmd_code` equals byte 4. Byte 5 maps bit 3 to `busy_dly_en`, bit 2 to `short_pkt_en`, bit 1 to soft-reset enable and bit 0 to `skip_pin_rst`. Bits 7:4 of byte 5 have no effect.
- R6: When byte 5 has bit 0 = 1 and bit 1 = 0, `rst_cfg_err` is 1 and `soft_rst_en` is forced to 1. Otherwise `rst_cfg_err` is 0 and `soft_rst_en` equals bit 1.
- R7: `pio_mode` is 4 if byte 7 bit 1 and `drv_pio_caps[1]` are both set. Otherwise it is 3 if byte 7 bit 0 and `drv_pio_caps[0]` are both set. Otherwise it is 0. Byte 7 bits 7:2 have no effect.
- R8: The UDMA candidates are byte 6 bits 5:0 ANDed with `drv_udma_caps`, where bit n means mode n, and then restricted to modes 2 and 4. `udma_mode` is the highest candidate and `udma_en` is 1 only if a candidate exists and the type enable allows it. When `udma_en` is 0, `udma_mode` is 0. Modes 0, 1, 3 and 5 are never chosen.
- R9: When `drv_is_atapi` is 1, byte 6 bit 6 is the UDMA master enable and bit 7 is ignored. When it is 0, bit 7 is the master enable and bit 6 is ignored.
- R10: `pio_mode`, `udma_en` and `udma_mode` follow changes on the drive inputs with exactly one clock of delay. The header fields and the mode flag keep their values until the next reset.
- R11: While reset is asserted, `rd_req`, `done`, `test_mode` and every configuration and mode output are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| rd_req | output | 1 | Byte-read request, held until answered |
| rd_dev | output | 7 | Two-wire device address of the memory |
| rd_addr | output | 8 | Byte address being read |
| rd_ack | input | 1 | Read answered, `rd_data` valid this cycle |
| rd_nak | input | 1 | Read refused by the memory |
| rd_data | input | 8 | Byte returned with `rd_ack` |
| drv_is_atapi | input | 1 | Attached drive uses packet commands |
| drv_pio_caps | input | 2 | Drive supports PIO 4 (bit 1) and PIO 3 (bit 0) |
| drv_udma_caps | input | 6 | Drive UDMA support, bit n = mode n |
| done | output | 1 | One-cycle pulse when loading ends |
| test_mode | output | 1 | Manufacturing test mode selected |
| init_tmo | output | 8 | Drive initialization timeout, 128 ms units |
| vcmd_code | output | 8 | Vendor command designator value |
| busy_dly_en | output | 1 | Busy-bit delay enable |
| short_pkt_en | output | 1 | Short packet before stall enable |
| soft_rst_en | output | 1 | Soft reset during init (after fallback) |
| skip_pin_rst | output | 1 | Skip the hardware reset pin |
| rst_cfg_err | output | 1 | Illegal reset-method combination seen |
| pio_mode | output | 3 | Resolved PIO mode: 0, 3 or 4 |
| udma_en | output | 1 | UDMA transfers in use |
| udma_mode | output | 3 | Resolved UDMA mode: 2 or 4 (0 when off) |

## Verification
The main stimulus is 64 header loads. Between them the flag byte, both UDMA type enables, the UDMA enable mask and the PIO enables all change. Under each load the bench sweeps every UDMA capability mask for both drive types. These sweeps tell apart a priority that picks the wrong end, a reserved mode that leaks through, a type enable taken from the wrong bit, and a PIO floor that is not enforced. Separate loads corrupt each signature byte in turn, refuse the read, or leave it unanswered. These show whether the block stops after the right number of reads, whether it waits out the full timeout, and whether its outputs stay clear in test mode.

// File: rtl/cfg_loader_pkg.sv
`timescale 1ns/1ps
package cfg_loader_pkg;

   // sequencer states
   typedef enum logic [1:0] {
      SQ_GAP = 2'd0,
      SQ_REQ = 2'd1,
      SQ_END = 2'd2
   } seq_st_e;

   // header layout: the byte index is behaviour (fields decoded by position)
   localparam int HDR_LEN  = 8;
   localparam int SIG_LEN  = 2;
   localparam int IX_TMO   = 3;
   localparam int IX_VCMD  = 4;
   localparam int IX_FLAG  = 5;
   localparam int IX_UDMA  = 6;
   localparam int IX_PIO   = 7;

   // bit positions inside the flag and UDMA bytes
   localparam int FB_SKIP  = 0;
   localparam int FB_SRST  = 1;
   localparam int FB_SHORT = 2;
   localparam int FB_BUSY  = 3;
   localparam int UB_ATAPI = 6;
   localparam int UB_ATA   = 7;

   // PIO mode codes
   localparam logic [2:0] PIO_M0 = 3'd0;
   localparam logic [2:0] PIO_M3 = 3'd3;
   localparam logic [2:0] PIO_M4 = 3'd4;

   typedef struct packed {
      logic busy_dly;
      logic short_pkt;
      logic srst;
      logic skip_pin;
   } rst_flags_t;

endpackage

// File: rtl/cfg_rd_seq.sv
`timescale 1ns/1ps
module cfg_rd_seq
   import cfg_loader_pkg::*;
#(
   parameter int          ADDR_W      = 8,
   parameter int          DATA_W      = 8,
   parameter int          NBYTES      = 8,
   parameter int          NSIG        = 2,
   parameter logic [7:0]  SIG_VAL     = 8'h4D,
   parameter int          RSP_TIMEOUT = 64
) (
   input  logic                       clk,
   input  logic                       rst_n,
   output logic                       rd_req,
   output logic [ADDR_W-1:0]          rd_addr,
   input  logic                       rd_ack,
   input  logic                       rd_nak,
   input  logic [DATA_W-1:0]          rd_data,
   output logic                       byte_vld,
   output logic [$clog2(NBYTES)-1:0]  byte_idx,
   output logic                       fin_pulse,
   output logic                       fail
);

   localparam int IDX_W = $clog2(NBYTES);
   localparam int TMO_W = $clog2(RSP_TIMEOUT + 1);
   localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NBYTES - 1);
   localparam logic [IDX_W-1:0] SIG_END  = IDX_W'(NSIG);
   localparam logic [TMO_W-1:0] TMO_LAST = TMO_W'(RSP_TIMEOUT - 1);

   seq_st_e           st_q;
   logic [IDX_W-1:0]  idx_q;
   logic [TMO_W-1:0]  tmo_q;
   logic              fin_q;
   logic              fail_q;

   logic in_req;
   logic tmo_hit;
   logic sig_bad;

   assign in_req  = (st_q == SQ_REQ);
   assign tmo_hit = (tmo_q == TMO_LAST);
   assign sig_bad = (idx_q < SIG_END) && (rd_data != DATA_W'(SIG_VAL));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= SQ_GAP;
         idx_q  <= '0;
         tmo_q  <= '0;
         fin_q  <= 1'b0;
         fail_q <= 1'b0;
      end else begin
         fin_q <= 1'b0;
         unique case (st_q)
            SQ_GAP: begin
               tmo_q <= '0;
               st_q  <= SQ_REQ;
            end
            SQ_REQ: begin
               if (rd_nak || (!rd_ack && tmo_hit)) begin
                  // refused or silent memory
                  fail_q <= 1'b1;
                  fin_q  <= 1'b1;
                  st_q   <= SQ_END;
               end else if (rd_ack) begin
                  if (sig_bad) begin
                     fail_q <= 1'b1;
                     fin_q  <= 1'b1;
                     st_q   <= SQ_END;
                  end else if (idx_q == LAST_IDX) begin
                     fin_q  <= 1'b1;
                     st_q   <= SQ_END;
                  end else begin
                     idx_q  <= idx_q + 1'b1;
                     st_q   <= SQ_GAP;
                  end
               end else begin
                  tmo_q <= tmo_q + 1'b1;
               end
            end
            default: st_q <= SQ_END;
         endcase
      end
   end

   assign rd_req    = in_req;
   assign rd_addr   = ADDR_W'(idx_q);
   assign byte_vld  = in_req && rd_ack && !rd_nak;
   assign byte_idx  = idx_q;
   assign fin_pulse = fin_q;
   assign fail      = fail_q;

endmodule

// File: rtl/cfg_hdr_regs.sv
`timescale 1ns/1ps
module cfg_hdr_regs
   import cfg_loader_pkg::*;
#(
   parameter int IDX_W      = 3,
   parameter int UDMA_MODES = 6
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   byte_vld,
   input  logic [IDX_W-1:0]       byte_idx,
   input  logic [7:0]             byte_data,
   output logic                   normal_o,
   output logic [7:0]             tmo_o,
   output logic [7:0]             vcmd_o,
   output rst_flags_t             flags_o,
   output logic                   rst_err_o,
   output logic [1:0]             udma_type_o,
   output logic [UDMA_MODES-1:0]  udma_mask_o,
   output logic [1:0]             pio_en_o
);

   localparam logic [IDX_W-1:0] I_TMO  = IDX_W'(IX_TMO);
   localparam logic [IDX_W-1:0] I_VCMD = IDX_W'(IX_VCMD);
   localparam logic [IDX_W-1:0] I_FLAG = IDX_W'(IX_FLAG);
   localparam logic [IDX_W-1:0] I_UDMA = IDX_W'(IX_UDMA);
   localparam logic [IDX_W-1:0] I_PIO  = IDX_W'(IX_PIO);
   localparam logic [IDX_W-1:0] I_LAST = IDX_W'(HDR_LEN - 1);

   logic                   normal_q;
   logic [7:0]             tmo_q;
   logic [7:0]             vcmd_q;
   rst_flags_t             flg_q;
   logic [1:0]             utype_q;   // [1] ATA enable, [0] ATAPI enable
   logic [UDMA_MODES-1:0]  umask_q;
   logic [1:0]             pio_q;

   // only the bits that carry meaning are kept; reserved bits are dropped here
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         normal_q <= 1'b0;
         tmo_q    <= '0;
         vcmd_q   <= '0;
         flg_q    <= '0;
         utype_q  <= '0;
         umask_q  <= '0;
         pio_q    <= '0;
      end else if (byte_vld) begin
         unique case (byte_idx)
            I_TMO:  tmo_q  <= byte_data;
            I_VCMD: vcmd_q <= byte_data;
            I_FLAG: begin
               flg_q.busy_dly  <= byte_data[FB_BUSY];
               flg_q.short_pkt <= byte_data[FB_SHORT];
               flg_q.srst      <= byte_data[FB_SRST];
               flg_q.skip_pin  <= byte_data[FB_SKIP];
            end
            I_UDMA: begin
               utype_q <= {byte_data[UB_ATA], byte_data[UB_ATAPI]};
               umask_q <= byte_data[UDMA_MODES-1:0];
            end
            default: ;
         endcase
         // the last byte is only reached once the signature has passed
         if (byte_idx == I_PIO)  pio_q    <= byte_data[1:0];
         if (byte_idx == I_LAST) normal_q <= 1'b1;
      end
   end

   logic bad_combo;
   assign bad_combo = flg_q.skip_pin && !flg_q.srst;

   // everything reads zero until (and unless) normal mode is reached
   always_comb begin
      normal_o          = normal_q;
      tmo_o             = normal_q ? tmo_q   : '0;
      vcmd_o            = normal_q ? vcmd_q  : '0;
      udma_type_o       = normal_q ? utype_q : '0;
      udma_mask_o       = normal_q ? umask_q : '0;
      pio_en_o          = normal_q ? pio_q   : '0;
      flags_o           = normal_q ? flg_q   : '0;
      flags_o.srst      = normal_q && (flg_q.srst || bad_combo);
      rst_err_o         = normal_q && bad_combo;
   end

endmodule

// File: rtl/cfg_mode_resolve.sv
`timescale 1ns/1ps
module cfg_mode_resolve
   import cfg_loader_pkg::*;
#(
   parameter int                    UDMA_MODES = 6,
   parameter logic [UDMA_MODES-1:0] UDMA_LEGAL = 6'b010100,
   parameter bit                    REG_OUT    = 1'b1
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          normal,
   input  logic                          drv_is_atapi,
   input  logic [1:0]                    drv_pio_caps,
   input  logic [UDMA_MODES-1:0]         drv_udma_caps,
   input  logic [1:0]                    udma_type,
   input  logic [UDMA_MODES-1:0]         udma_mask,
   input  logic [1:0]                    pio_en,
   output logic [2:0]                    pio_mode,
   output logic                          udma_en,
   output logic [$clog2(UDMA_MODES)-1:0] udma_mode
);

   localparam int UM_W = $clog2(UDMA_MODES);

   logic                  type_ok;
   logic [UDMA_MODES-1:0] cand;
   logic [UM_W-1:0]       sel_c;
   logic                  any_c;
   logic [1:0]            pio_hit;
   logic [2:0]            pio_c;

   // the enable that does not match the drive type plays no part
   assign type_ok = normal && (drv_is_atapi ? udma_type[0] : udma_type[1]);
   assign cand    = udma_mask & drv_udma_caps & UDMA_LEGAL & {UDMA_MODES{type_ok}};
   assign any_c   = |cand;

   // highest set candidate wins: later iterations overwrite earlier ones
   always_comb begin
      sel_c = '0;
      for (int i = 0; i < UDMA_MODES; i++) begin
         if (cand[i]) sel_c = UM_W'(i);
      end
   end

   // PIO 0 is the floor and needs no enable
   assign pio_hit = pio_en & drv_pio_caps & {2{normal}};
   always_comb begin
      if (pio_hit[1])      pio_c = PIO_M4;
      else if (pio_hit[0]) pio_c = PIO_M3;
      else                 pio_c = PIO_M0;
   end

   generate
      if (REG_OUT) begin : g_reg
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               pio_mode  <= PIO_M0;
               udma_en   <= 1'b0;
               udma_mode <= '0;
            end else begin
               pio_mode  <= pio_c;
               udma_en   <= any_c;
               udma_mode <= sel_c;
            end
         end
      end else begin : g_comb
         assign pio_mode  = pio_c;
         assign udma_en   = any_c;
         assign udma_mode = sel_c;
      end
   endgenerate

endmodule

// File: rtl/cfg_loader.sv
`timescale 1ns/1ps
module cfg_loader
   import cfg_loader_pkg::*;
#(
   parameter int                    ADDR_W      = 8,
   parameter int                    DATA_W      = 8,
   parameter logic [6:0]            DEV_ADDR    = 7'h04,
   parameter logic [7:0]            SIG_VAL     = 8'h4D,
   parameter int                    RSP_TIMEOUT = 64,
   parameter int                    UDMA_MODES  = 6,
   parameter logic [UDMA_MODES-1:0] UDMA_LEGAL  = 6'b010100,
   parameter bit                    REG_RESOLVE = 1'b1
) (
   input  logic                          clk,
   input  logic                          rst_n,
   output logic                          rd_req,
   output logic [6:0]                    rd_dev,
   output logic [ADDR_W-1:0]             rd_addr,
   input  logic                          rd_ack,
   input  logic                          rd_nak,
   input  logic [DATA_W-1:0]             rd_data,
   input  logic                          drv_is_atapi,
   input  logic [1:0]                    drv_pio_caps,
   input  logic [UDMA_MODES-1:0]         drv_udma_caps,
   output logic                          done,
   output logic                          test_mode,
   output logic [7:0]                    init_tmo,
   output logic [7:0]                    vcmd_code,
   output logic                          busy_dly_en,
   output logic                          short_pkt_en,
   output logic                          soft_rst_en,
   output logic                          skip_pin_rst,
   output logic                          rst_cfg_err,
   output logic [2:0]                    pio_mode,
   output logic                          udma_en,
   output logic [$clog2(UDMA_MODES)-1:0] udma_mode
);

   localparam int IDX_W = $clog2(HDR_LEN);

   // elaboration-time checks on the parameter set
   if (DATA_W != 8) begin : g_bad_dw
      $error("cfg_loader: DATA_W must be 8");
   end
   if (ADDR_W < IDX_W) begin : g_bad_aw
      $error("cfg_loader: ADDR_W too narrow for the header");
   end
   if (UDMA_MODES > 6 || UDMA_MODES < 2) begin : g_bad_um
      $error("cfg_loader: UDMA_MODES must lie in 2..6");
   end
   if (RSP_TIMEOUT < 2) begin : g_bad_to
      $error("cfg_loader: RSP_TIMEOUT must be at least 2");
   end

   logic              byte_vld;
   logic [IDX_W-1:0]  byte_idx;
   logic              fin_pulse;
   logic              fail;
   logic              normal;
   rst_flags_t        flags;
   logic [1:0]        udma_type;
   logic [UDMA_MODES-1:0] udma_mask;
   logic [1:0]        pio_en;

   cfg_rd_seq #(
      .ADDR_W      (ADDR_W),
      .DATA_W      (DATA_W),
      .NBYTES      (HDR_LEN),
      .NSIG        (SIG_LEN),
      .SIG_VAL     (SIG_VAL),
      .RSP_TIMEOUT (RSP_TIMEOUT)
   ) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .rd_req    (rd_req),
      .rd_addr   (rd_addr),
      .rd_ack    (rd_ack),
      .rd_nak    (rd_nak),
      .rd_data   (rd_data),
      .byte_vld  (byte_vld),
      .byte_idx  (byte_idx),
      .fin_pulse (fin_pulse),
      .fail      (fail)
   );

   cfg_hdr_regs #(
      .IDX_W      (IDX_W),
      .UDMA_MODES (UDMA_MODES)
   ) u_regs (
      .clk         (clk),
      .rst_n       (rst_n),
      .byte_vld    (byte_vld),
      .byte_idx    (byte_idx),
      .byte_data   (rd_data),
      .normal_o    (normal),
      .tmo_o       (init_tmo),
      .vcmd_o      (vcmd_code),
      .flags_o     (flags),
      .rst_err_o   (rst_cfg_err),
      .udma_type_o (udma_type),
      .udma_mask_o (udma_mask),
      .pio_en_o    (pio_en)
   );

   cfg_mode_resolve #(
      .UDMA_MODES (UDMA_MODES),
      .UDMA_LEGAL (UDMA_LEGAL),
      .REG_OUT    (REG_RESOLVE)
   ) u_res (
      .clk           (clk),
      .rst_n         (rst_n),
      .normal        (normal),
      .drv_is_atapi  (drv_is_atapi),
      .drv_pio_caps  (drv_pio_caps),
      .drv_udma_caps (drv_udma_caps),
      .udma_type     (udma_type),
      .udma_mask     (udma_mask),
      .pio_en        (pio_en),
      .pio_mode      (pio_mode),
      .udma_en       (udma_en),
      .udma_mode     (udma_mode)
   );

   assign rd_dev       = DEV_ADDR;
   assign done         = fin_pulse;
   assign test_mode    = fail;
   assign busy_dly_en  = flags.busy_dly;
   assign short_pkt_en = flags.short_pkt;
   assign soft_rst_en  = flags.srst;
   assign skip_pin_rst = flags.skip_pin;

endmodule

// File: rtl/cfg_loader_chk.sv
`timescale 1ns/1ps
module cfg_loader_chk #(
   parameter int                    ADDR_W     = 8,
   parameter int                    UDMA_MODES = 6,
   parameter logic [UDMA_MODES-1:0] UDMA_LEGAL = 6'b010100
) (
   input logic                          clk,
   input logic                          rst_n,
   input logic                          rd_req,
   input logic [ADDR_W-1:0]             rd_addr,
   input logic                          rd_ack,
   input logic                          rd_nak,
   input logic                          done,
   input logic                          test_mode,
   input logic [7:0]                    init_tmo,
   input logic [7:0]                    vcmd_code,
   input logic                          soft_rst_en,
   input logic                          rst_cfg_err,
   input logic [2:0]                    pio_mode,
   input logic                          udma_en,
   input logic [$clog2(UDMA_MODES)-1:0] udma_mode
);

   logic seen_done;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    seen_done <= 1'b0;
      else if (done) seen_done <= 1'b1;
   end

   // R1
   addr_in_hdr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rd_req |-> (rd_addr < ADDR_W'(8)));

   // R1
   req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_req && !rd_ack && !rd_nak) |=> ((rd_req && $stable(rd_addr)) || test_mode));

   // R2
   single_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      seen_done |-> !done);

   // R3
   test_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      test_mode |-> (!rd_req && init_tmo == 8'h00 && vcmd_code == 8'h00
                     && pio_mode == 3'd0 && !udma_en));

   // R4
   nak_to_test_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_req && rd_nak) |=> test_mode);

   // R6
   err_forces_srst_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rst_cfg_err |-> soft_rst_en);

   // R7
   pio_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pio_mode == 3'd0 || pio_mode == 3'd3 || pio_mode == 3'd4));

   // R8
   udma_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
      udma_en |-> UDMA_LEGAL[udma_mode]);

   // R8
   udma_off_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !udma_en |-> (udma_mode == '0));

   // R10
   cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      seen_done |-> ($stable(init_tmo) && $stable(vcmd_code) && $stable(test_mode)));

endmodule

bind cfg_loader cfg_loader_chk #(
   .ADDR_W     (ADDR_W),
   .UDMA_MODES (UDMA_MODES),
   .UDMA_LEGAL (UDMA_LEGAL)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .rd_req      (rd_req),
   .rd_addr     (rd_addr),
   .rd_ack      (rd_ack),
   .rd_nak      (rd_nak),
   .done        (done),
   .test_mode   (test_mode),
   .init_tmo    (init_tmo),
   .vcmd_code   (vcmd_code),
   .soft_rst_en (soft_rst_en),
   .rst_cfg_err (rst_cfg_err),
   .pio_mode    (pio_mode),
   .udma_en     (udma_en),
   .udma_mode   (udma_mode)
);

// File: tb/tb_cfg_loader.sv
`timescale 1ns/1ps
module tb_cfg_loader;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       rd_req;
   logic [6:0] rd_dev;
   logic [7:0] rd_addr;
   logic       rd_ack = 1'b0;
   logic       rd_nak = 1'b0;
   logic [7:0] rd_data = 8'h00;
   logic       drv_is_atapi = 1'b0;
   logic [1:0] drv_pio_caps = 2'b00;
   logic [5:0] drv_udma_caps = 6'h00;
   logic       done, test_mode;
   logic [7:0] init_tmo, vcmd_code;
   logic       busy_dly_en, short_pkt_en, soft_rst_en, skip_pin_rst, rst_cfg_err;
   logic [2:0] pio_mode;
   logic       udma_en;
   logic [2:0] udma_mode;

   always #2.5 clk = ~clk;

   cfg_loader dut (
      .clk(clk), .rst_n(rst_n), .rd_req(rd_req), .rd_dev(rd_dev), .rd_addr(rd_addr),
      .rd_ack(rd_ack), .rd_nak(rd_nak), .rd_data(rd_data),
      .drv_is_atapi(drv_is_atapi), .drv_pio_caps(drv_pio_caps), .drv_udma_caps(drv_udma_caps),
      .done(done), .test_mode(test_mode), .init_tmo(init_tmo), .vcmd_code(vcmd_code),
      .busy_dly_en(busy_dly_en), .short_pkt_en(short_pkt_en), .soft_rst_en(soft_rst_en),
      .skip_pin_rst(skip_pin_rst), .rst_cfg_err(rst_cfg_err), .pio_mode(pio_mode),
      .udma_en(udma_en), .udma_mode(udma_mode)
   );

   int nchk = 0;
   int nfail = 0;
   bit finished = 1'b0;

   task automatic check(input bit ok, input string req, input int act, input int exp);
      nchk++;
      if (!ok) begin
         nfail++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
      end
   endtask

   // behavioural memory: answers after LAT negedges of a held request
   logic [7:0] mem [8];
   int rsp_mode = 0;       // 0 answer, 1 refuse, 2 silent
   int lat = 2;
   int cnt = 0;
   int n_reads = 0;
   int exp_addr = 0;
   int ord_err = 0;
   int done_cnt = 0;

   always @(negedge clk) begin
      rd_ack = 1'b0;
      rd_nak = 1'b0;
      if (!rst_n) begin
         cnt = 0; n_reads = 0; exp_addr = 0; ord_err = 0; done_cnt = 0;
      end else begin
         if (done) done_cnt++;
         if (rd_req) begin
            cnt++;
            if (cnt >= lat && rsp_mode != 2) begin
               if (int'(rd_addr) != exp_addr || rd_dev != 7'h04) ord_err++;
               if (rsp_mode == 1) rd_nak = 1'b1;
               else begin
                  rd_ack  = 1'b1;
                  rd_data = mem[rd_addr[2:0]];
               end
               exp_addr++;
               n_reads++;
               cnt = 0;
            end
         end else begin
            cnt = 0;
         end
      end
   end

   int wait_cyc;

   task automatic load(input logic [7:0] b [8], input int mode);
      for (int i = 0; i < 8; i++) mem[i] = b[i];
      rsp_mode = mode;
      @(negedge clk);
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      wait_cyc = 0;
      while (!done && wait_cyc < 1000) begin
         @(negedge clk);
         wait_cyc++;
      end
      check(wait_cyc < 1000, "R2 done reached", wait_cyc, 0);
      repeat (2) @(negedge clk);
   endtask

   function automatic int exp_pio(input logic [1:0] en, input logic [1:0] cap);
      logic [1:0] h;
      h = en & cap;
      return h[1] ? 4 : (h[0] ? 3 : 0);
   endfunction

   initial begin
      logic [7:0] hb [8];
      logic [5:0] kk;
      // R11: state while reset is held
      repeat (2) @(negedge clk);
      check(rd_req == 0 && done == 0 && test_mode == 0, "R11 reset handshake", int'(rd_req), 0);
      check(init_tmo == 0 && vcmd_code == 0 && pio_mode == 0 && udma_en == 0 && rst_cfg_err == 0,
            "R11 reset outputs", int'(init_tmo), 0);

      for (int k = 0; k < 64; k++) begin
         kk = 6'(k);
         hb[0] = 8'h4D; hb[1] = 8'h4D; hb[2] = 8'h5A;
         hb[3] = 8'(k * 4 + 1);
         hb[4] = 8'hC0 ^ 8'(k);
         hb[5] = {4'b1010, kk[3:0]};
         hb[6] = {kk[0], kk[1] ^ kk[5], kk};
         hb[7] = {6'b111111, kk[3:2]};
         drv_is_atapi = 1'b0; drv_pio_caps = 2'b00; drv_udma_caps = 6'h00;
         load(hb, 0);
         check(test_mode == 0, "R2 normal mode", int'(test_mode), 0);
         check(done_cnt == 1, "R2 done pulses", done_cnt, 1);
         check(n_reads == 8 && ord_err == 0, "R1 read order", n_reads * 100 + ord_err, 800);
         check(init_tmo == hb[3], "R5 timeout field", int'(init_tmo), int'(hb[3]));
         check(vcmd_code == hb[4], "R5 command designator", int'(vcmd_code), int'(hb[4]));
         check(busy_dly_en == hb[5][3], "R5 busy delay", int'(busy_dly_en), int'(hb[5][3]));
         check(short_pkt_en == hb[5][2], "R5 short packet", int'(short_pkt_en), int'(hb[5][2]));
         check(skip_pin_rst == hb[5][0], "R5 skip pin reset", int'(skip_pin_rst), int'(hb[5][0]));
         check(soft_rst_en == (hb[5][1] | hb[5][0]), "R6 soft reset fallback",
               int'(soft_rst_en), int'(hb[5][1] | hb[5][0]));
         check(rst_cfg_err == (hb[5][0] & ~hb[5][1]), "R6 reset combo error",
               int'(rst_cfg_err), int'(hb[5][0] & ~hb[5][1]));
         for (int t = 0; t < 2; t++) begin
            for (int c = 0; c < 64; c++) begin
               logic       allow;
               logic [5:0] cand;
               int         em;
               logic [1:0] pc;
               pc = 2'(c) ^ 2'(t);
               drv_is_atapi = t[0]; drv_udma_caps = 6'(c); drv_pio_caps = pc;
               @(negedge clk);
               allow = t[0] ? hb[6][6] : hb[6][7];
               cand  = hb[6][5:0] & 6'(c) & 6'b010100;
               em    = (allow && cand != 0) ? (cand[4] ? 4 : 2) : 0;
               check(int'(pio_mode) == exp_pio(hb[7][1:0], pc), "R7 pio resolve",
                     int'(pio_mode), exp_pio(hb[7][1:0], pc));
               check(udma_en == (allow && cand != 0), "R8 R9 udma enable",
                     int'(udma_en), int'(allow && cand != 0));
               check(int'(udma_mode) == em, "R8 udma mode", int'(udma_mode), em);
            end
         end
         // R10: one clock of lag, fields still held
         if (hb[7][1]) begin
            drv_pio_caps = 2'b10;
            @(negedge clk);
            drv_pio_caps = 2'b00;
            #1;
            check(pio_mode == 3'd4, "R10 lag before edge", int'(pio_mode), 4);
            @(negedge clk);
            check(pio_mode == 3'd0, "R10 after one edge", int'(pio_mode), 0);
         end
         check(init_tmo == hb[3] && done_cnt == 1 && test_mode == 0, "R10 fields held",
               int'(init_tmo), int'(hb[3]));
      end

      // R3: second signature byte wrong
      hb[0] = 8'h4D; hb[1] = 8'h4C; hb[3] = 8'h80; hb[4] = 8'h24; hb[5] = 8'h0F;
      hb[6] = 8'hFF; hb[7] = 8'h03;
      drv_is_atapi = 1'b0; drv_pio_caps = 2'b11; drv_udma_caps = 6'h3F;
      load(hb, 0);
      check(test_mode == 1, "R3 bad second byte", int'(test_mode), 1);
      check(n_reads == 2, "R3 stops after byte 1", n_reads, 2);
      check(done_cnt == 1, "R3 done pulse", done_cnt, 1);
      check(init_tmo == 0 && vcmd_code == 0 && soft_rst_en == 0 && busy_dly_en == 0,
            "R3 fields clear", int'(init_tmo), 0);
      check(pio_mode == 0 && udma_en == 0, "R3 modes floor", int'(pio_mode), 0);
      repeat (20) @(negedge clk);
      check(rd_req == 0 && n_reads == 2, "R3 no further reads", n_reads, 2);

      // R3: first signature byte wrong
      hb[0] = 8'h00; hb[1] = 8'h4D;
      load(hb, 0);
      check(test_mode == 1 && n_reads == 1, "R3 bad first byte", n_reads, 1);

      // R4: refused read
      hb[0] = 8'h4D;
      load(hb, 1);
      check(test_mode == 1 && n_reads == 1, "R4 refused read", n_reads, 1);
      check(pio_mode == 0 && udma_en == 0, "R4 modes floor", int'(pio_mode), 0);

      // R4: silent memory, timeout not early
      load(hb, 2);
      check(test_mode == 1 && n_reads == 0, "R4 silent memory", int'(test_mode), 1);
      check(wait_cyc >= 64, "R4 timeout length", wait_cyc, 64);

      if (!finished) begin
         finished = 1'b1;
         $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
         $finish;
      end
   end

   initial begin
      #900000;
      if (!finished) begin
         finished = 1'b1;
         nchk++;
         nfail++;
         $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
         $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
         $finish;
      end
   end

endmodule